// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

This block turns asynchronous pin activity into interrupt requests for a processor. It watches one dedicated external interrupt pin and a group of general-purpose pins (six by default). The dedicated pin has a programmable sense mode: it can request while held low, or it can latch a flag on any change, on a falling edge only, or on a rising edge only. The pin group shares one request. That request fires when any pin whose mask bit is set changes level, provided a group-wide enable is on.

Every pin passes through a synchroniser before any decision is made, and edges are judged on the synchronised value. Software programs the sense code, the two enables and the group mask through dedicated write strobes. Latched flags are cleared by the per-source acknowledge from the interrupt logic or by a write-one-to-clear strobe. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, both flags and both requests are 0, the sense code is 00 (low level), the external enable and the group enable are 0, and every mask bit is 0.
- R2: With sense code 00, ext_req_o equals the external enable ANDed with the inverted synchronised pin, and ext_flag_o never sets. A pin change driven between clock edges reaches ext_req_o after the second rising edge that follows it.
- R3: With sense code 01, both a falling and a rising transition of the synchronised external pin set ext_flag_o. The flag becomes visible after the third rising edge that follows the pin change.
- R4: With sense code 10, only a high-to-low transition of the synchronised external pin sets ext_flag_o.
- R5: With sense code 11, only a low-to-high transition of the synchronised external pin sets ext_flag_o.
- R6: ext_flag_o stays set until ext_ack_i is high or a clear strobe is given with bit 0 of flag_clr_i set. Bit 1 alone leaves it untouched. A new event in the same cycle as a clear leaves the flag set.
- R7: In the edge modes (01, 10, 11), ext_req_o equals ext_flag_o ANDed with the external enable. The flag sets even while the enable is 0.
- R8: grp_flag_o sets when the group enable is 1 and at least one pin whose mask bit is 1 has a synchronised value different from the one it had one cycle earlier. grp_req_o equals grp_flag_o ANDed with the group enable.
- R9: Changes on pins whose mask bit is 0, and any pin change while the group enable is 0, leave grp_flag_o at 0.
- R10: grp_flag_o stays set until grp_ack_i is high or a clear strobe is given with bit 1 of flag_clr_i set. Neither ext_ack_i nor bit 0 of the strobe clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ext_pin_i | input | 1 | Dedicated external interrupt pin (asynchronous) |
| grp_pin_i | input | NPINS | Pin group for change detection (asynchronous) |
| sense_we_i | input | 1 | Write strobe for the sense code |
| sense_wdata_i | input | 2 | Sense code: 00 low level, 01 any change, 10 falling, 11 rising |
| ext_en_we_i | input | 1 | Write strobe for the external enable |
| ext_en_wdata_i | input | 1 | External enable value |
| grp_en_we_i | input | 1 | Write strobe for the group enable |
| grp_en_wdata_i | input | 1 | Group enable value |
| mask_we_i | input | 1 | Write strobe for the pin mask |
| mask_wdata_i | input | NPINS | Per-pin mask, 1 = pin monitored |
| flag_clr_we_i | input | 1 | Write-one-to-clear strobe for the flags |
| flag_clr_i | input | 2 | Bit 0 clears the external flag, bit 1 clears the group flag |
| ext_ack_i | input | 1 | Acknowledge that clears the external flag |
| grp_ack_i | input | 1 | Acknowledge that clears the group flag |
| ext_flag_o | output | 1 | Latched external event flag |
| grp_flag_o | output | 1 | Latched group change flag |
| ext_req_o | output | 1 | External interrupt request |
| grp_req_o | output | 1 | Group interrupt request |

## Verification
The bench runs every sense code against both transition directions and samples one cycle before the flag is due as well as on the due cycle. A decoder that mixes up the falling and rising codes, or that judges edges on the raw pin, fails there. It also sweeps all 64 mask values against a toggle on each pin. This exposes a mask bit wired to the wrong pin, or detection that ignores the mask or the group enable. Targeted cases make an acknowledge land in the same cycle as a new event, and give a clear strobe for the other source only. A design that lets clear win, or that decodes the clear bits the wrong way round, loses or wrongly drops a flag. Finally, low-level mode is checked for a request that follows the pin in both directions with no flag left behind.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  // bit positions inside the write-one-to-clear vector
  localparam int unsigned CLR_EXT_BIT = 0;
  localparam int unsigned CLR_GRP_BIT = 1;
  localparam int unsigned CLR_WIDTH   = 2;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);

  localparam logic [WIDTH-1:0] RST_VAL = {WIDTH{IDLE}};

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;
  logic [WIDTH-1:0]             prev_q;
  logic [WIDTH-1:0]             prev_d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stg_d[s] = pin_i;
    end else begin : g_next
      always_comb stg_d[s] = stg_q[s-1];
    end
  end

  always_comb begin
    prev_d = stg_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      stg_q  <= stg_d;
      prev_q <= prev_d;
    end
  end

  assign sync_o = stg_q[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_ctl_pkg::*;
#(
  parameter int unsigned NPINS = 6
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             sense_we_i,
  input  logic [1:0]       sense_wdata_i,
  input  logic             ext_en_we_i,
  input  logic             ext_en_wdata_i,
  input  logic             grp_en_we_i,
  input  logic             grp_en_wdata_i,
  input  logic             mask_we_i,
  input  logic [NPINS-1:0] mask_wdata_i,
  output sense_e           sense_o,
  output logic             ext_en_o,
  output logic             grp_en_o,
  output logic [NPINS-1:0] mask_o
);

  sense_e           sense_q, sense_d;
  logic             ext_en_q, ext_en_d;
  logic             grp_en_q, grp_en_d;
  logic [NPINS-1:0] mask_q, mask_d;

  always_comb begin
    sense_d  = sense_e'(sense_wdata_i);
    ext_en_d = ext_en_wdata_i;
    grp_en_d = grp_en_wdata_i;
    mask_d   = mask_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q  <= SENSE_LOW;
      ext_en_q <= 1'b0;
      grp_en_q <= 1'b0;
      mask_q   <= '0;
    end else begin
      if (sense_we_i)  sense_q  <= sense_d;
      if (ext_en_we_i) ext_en_q <= ext_en_d;
      if (grp_en_we_i) grp_en_q <= grp_en_d;
      if (mask_we_i)   mask_q   <= mask_d;
    end
  end

  assign sense_o  = sense_q;
  assign ext_en_o = ext_en_q;
  assign grp_en_o = grp_en_q;
  assign mask_o   = mask_q;

endmodule

// File: rtl/irq_ext_sense.sv
module irq_ext_sense
  import irq_ctl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_ni,
  input  sense_e sense_i,
  input  logic   en_i,
  input  logic   lvl_i,
  input  logic   prev_i,
  input  logic   clr_i,
  output logic   evt_o,
  output logic   flag_o,
  output logic   req_o
);

  logic rise, fall;
  logic evt;
  logic flag_q, flag_d, flag_ld;

  always_comb begin
    rise = lvl_i & ~prev_i;
    fall = ~lvl_i & prev_i;
    unique case (sense_i)
      SENSE_LOW:  evt = 1'b0;
      SENSE_ANY:  evt = rise | fall;
      SENSE_FALL: evt = fall;
      SENSE_RISE: evt = rise;
      default:    evt = 1'b0;
    endcase
  end

  // an event in the clearing cycle wins
  always_comb begin
    flag_ld = evt | clr_i;
    flag_d  = evt;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (flag_ld) begin
      flag_q <= flag_d;
    end
  end

  always_comb begin
    if (sense_i == SENSE_LOW) begin
      req_o = en_i & ~lvl_i;
    end else begin
      req_o = en_i & flag_q;
    end
  end

  assign evt_o  = evt;
  assign flag_o = flag_q;

endmodule

// File: rtl/irq_pcint_det.sv
module irq_pcint_det #(
  parameter int unsigned NPINS = 6
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] prev_i,
  input  logic             clr_i,
  output logic             evt_o,
  output logic             flag_o,
  output logic             req_o
);

  logic [NPINS-1:0] changed;
  logic             evt;
  logic             flag_q, flag_d, flag_ld;

  always_comb begin
    changed = (lvl_i ^ prev_i) & mask_i;
    evt     = en_i & (|changed);
    flag_ld = evt | clr_i;
    flag_d  = evt;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (flag_ld) begin
      flag_q <= flag_d;
    end
  end

  assign evt_o  = evt;
  assign flag_o = flag_q;
  assign req_o  = en_i & flag_q;

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int unsigned NPINS       = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2,
  parameter logic        PIN_IDLE    = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_pin_i,
  input  logic [NPINS-1:0]     grp_pin_i,
  input  logic                 sense_we_i,
  input  logic [1:0]           sense_wdata_i,
  input  logic                 ext_en_we_i,
  input  logic                 ext_en_wdata_i,
  input  logic                 grp_en_we_i,
  input  logic                 grp_en_wdata_i,
  input  logic                 mask_we_i,
  input  logic [NPINS-1:0]     mask_wdata_i,
  input  logic                 flag_clr_we_i,
  input  logic [CLR_WIDTH-1:0] flag_clr_i,
  input  logic                 ext_ack_i,
  input  logic                 grp_ack_i,
  output logic                 ext_flag_o,
  output logic                 grp_flag_o,
  output logic                 ext_req_o,
  output logic                 grp_req_o
);

  localparam int unsigned ALL_PINS = NPINS + 1;

  logic                rst_n_int;
  logic [ALL_PINS-1:0] pins_sync, pins_prev;
  sense_e              sense_q;
  logic                ext_en_q, grp_en_q;
  logic [NPINS-1:0]    mask_q;
  logic                ext_clr, grp_clr;
  logic                ext_evt, grp_evt;

  irq_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_n_int)
  );

  irq_pin_sync #(
    .WIDTH  (ALL_PINS),
    .STAGES (SYNC_STAGES),
    .IDLE   (PIN_IDLE)
  ) i_pin_sync (
    .clk    (clk),
    .rst_ni (rst_n_int),
    .pin_i  ({ext_pin_i, grp_pin_i}),
    .sync_o (pins_sync),
    .prev_o (pins_prev)
  );

  irq_cfg_regs #(.NPINS(NPINS)) i_cfg (
    .clk            (clk),
    .rst_ni         (rst_n_int),
    .sense_we_i     (sense_we_i),
    .sense_wdata_i  (sense_wdata_i),
    .ext_en_we_i    (ext_en_we_i),
    .ext_en_wdata_i (ext_en_wdata_i),
    .grp_en_we_i    (grp_en_we_i),
    .grp_en_wdata_i (grp_en_wdata_i),
    .mask_we_i      (mask_we_i),
    .mask_wdata_i   (mask_wdata_i),
    .sense_o        (sense_q),
    .ext_en_o       (ext_en_q),
    .grp_en_o       (grp_en_q),
    .mask_o         (mask_q)
  );

  always_comb begin
    ext_clr = ext_ack_i | (flag_clr_we_i & flag_clr_i[CLR_EXT_BIT]);
    grp_clr = grp_ack_i | (flag_clr_we_i & flag_clr_i[CLR_GRP_BIT]);
  end

  irq_ext_sense i_ext (
    .clk     (clk),
    .rst_ni  (rst_n_int),
    .sense_i (sense_q),
    .en_i    (ext_en_q),
    .lvl_i   (pins_sync[NPINS]),
    .prev_i  (pins_prev[NPINS]),
    .clr_i   (ext_clr),
    .evt_o   (ext_evt),
    .flag_o  (ext_flag_o),
    .req_o   (ext_req_o)
  );

  irq_pcint_det #(.NPINS(NPINS)) i_grp (
    .clk    (clk),
    .rst_ni (rst_n_int),
    .en_i   (grp_en_q),
    .mask_i (mask_q),
    .lvl_i  (pins_sync[NPINS-1:0]),
    .prev_i (pins_prev[NPINS-1:0]),
    .clr_i  (grp_clr),
    .evt_o  (grp_evt),
    .flag_o (grp_flag_o),
    .req_o  (grp_req_o)
  );

endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_ni,
  input logic [1:0] sense,
  input logic       ext_en,
  input logic       grp_en,
  input logic       ext_evt,
  input logic       grp_evt,
  input logic       ext_clr,
  input logic       grp_clr,
  input logic       ext_flag,
  input logic       grp_flag,
  input logic       ext_req,
  input logic       grp_req
);

  assert_level_no_flag_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (sense == 2'b00) |=> !$rose(ext_flag));

  assert_ext_sticky_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (ext_flag && !ext_clr) |=> ext_flag);

  assert_ext_clear_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (ext_clr && !ext_evt) |=> !ext_flag);

  assert_ext_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    ext_evt |=> ext_flag);

  assert_ext_gate_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    !ext_en |-> !ext_req);

  assert_grp_req_flag_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    grp_req |-> (grp_flag && grp_en));

  assert_grp_idle_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    !grp_en |=> !$rose(grp_flag));

  assert_grp_sticky_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (grp_flag && !grp_clr) |=> grp_flag);

  assert_grp_clear_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (grp_clr && !grp_evt) |=> !grp_flag);

endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk i_chk (
  .clk      (clk),
  .rst_ni   (rst_n_int),
  .sense    (sense_q),
  .ext_en   (ext_en_q),
  .grp_en   (grp_en_q),
  .ext_evt  (ext_evt),
  .grp_evt  (grp_evt),
  .ext_clr  (ext_clr),
  .grp_clr  (grp_clr),
  .ext_flag (ext_flag_o),
  .grp_flag (grp_flag_o),
  .ext_req  (ext_req_o),
  .grp_req  (grp_req_o)
);

// File: tb/test_pin_irq_ctrl.sv
module test_pin_irq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ext_pin;
  logic [NP-1:0] grp_pin;
  logic          sense_we, ext_en_we, grp_en_we, mask_we, clr_we;
  logic [1:0]    sense_wd, clr_bits;
  logic          ext_en_wd, grp_en_wd;
  logic [NP-1:0] mask_wd;
  logic          ext_ack, grp_ack;
  logic          ext_flag, grp_flag, ext_req, grp_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_ctrl #(.NPINS(NP)) i_pin_irq_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .ext_pin_i      (ext_pin),
    .grp_pin_i      (grp_pin),
    .sense_we_i     (sense_we),
    .sense_wdata_i  (sense_wd),
    .ext_en_we_i    (ext_en_we),
    .ext_en_wdata_i (ext_en_wd),
    .grp_en_we_i    (grp_en_we),
    .grp_en_wdata_i (grp_en_wd),
    .mask_we_i      (mask_we),
    .mask_wdata_i   (mask_wd),
    .flag_clr_we_i  (clr_we),
    .flag_clr_i     (clr_bits),
    .ext_ack_i      (ext_ack),
    .grp_ack_i      (grp_ack),
    .ext_flag_o     (ext_flag),
    .grp_flag_o     (grp_flag),
    .ext_req_o      (ext_req),
    .grp_req_o      (grp_req)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic set_sense(input logic [1:0] v);
    sense_we = 1'b1; sense_wd = v; tick(1); sense_we = 1'b0;
  endtask

  task automatic set_ext_en(input logic v);
    ext_en_we = 1'b1; ext_en_wd = v; tick(1); ext_en_we = 1'b0;
  endtask

  task automatic set_grp_en(input logic v);
    grp_en_we = 1'b1; grp_en_wd = v; tick(1); grp_en_we = 1'b0;
  endtask

  task automatic set_mask(input logic [NP-1:0] v);
    mask_we = 1'b1; mask_wd = v; tick(1); mask_we = 1'b0;
  endtask

  task automatic w1c(input logic [1:0] v);
    clr_we = 1'b1; clr_bits = v; tick(1); clr_we = 1'b0; clr_bits = 2'b00;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_pin = 1'b1; grp_pin = '1;
    sense_we = 0; ext_en_we = 0; grp_en_we = 0; mask_we = 0; clr_we = 0;
    sense_wd = 0; clr_bits = 0; ext_en_wd = 0; grp_en_wd = 0; mask_wd = 0;
    ext_ack = 0; grp_ack = 0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1: reset state
    chk(ext_flag, 1'b0, "R1", "ext flag after reset");
    chk(grp_flag, 1'b0, "R1", "grp flag after reset");
    chk(ext_req,  1'b0, "R1", "ext req after reset");
    chk(grp_req,  1'b0, "R1", "grp req after reset");
    // R1: external enable resets to 0
    ext_pin = 1'b0; tick(3);
    chk(ext_req, 1'b0, "R1", "low pin with enable at reset value");
    // R1: mask and group enable reset to 0
    grp_pin = '0; tick(3);
    chk(grp_flag, 1'b0, "R1", "group change with reset mask");
    grp_pin = '1; tick(3);
    // R1 + R2: sense code defaults to low level
    set_ext_en(1'b1);
    chk(ext_req, 1'b1, "R1", "low-level request with reset sense code");
    chk(ext_flag, 1'b0, "R2", "no flag in low-level mode");
    // R2: two-edge latency on release
    ext_pin = 1'b1; tick(1);
    chk(ext_req, 1'b1, "R2", "request one edge after pin rise");
    tick(1);
    chk(ext_req, 1'b0, "R2", "request dropped two edges after pin rise");
    chk(ext_flag, 1'b0, "R2", "no flag after level release");

    // R2..R5: every sense code against both directions
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        logic start, nxt, exp_flag, exp_req;
        string tag;
        start = (d == 0);
        nxt   = ~start;
        tag   = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
        ext_pin = start; tick(3);
        set_sense(m[1:0]);
        w1c(2'b01);
        case (m)
          0: exp_flag = 1'b0;
          1: exp_flag = 1'b1;
          2: exp_flag = (start == 1'b1);
          default: exp_flag = (start == 1'b0);
        endcase
        exp_req = (m == 0) ? ~nxt : exp_flag;
        ext_pin = nxt; tick(2);
        chk(ext_flag, 1'b0, tag, "flag one edge before due");
        tick(1);
        chk(ext_flag, exp_flag, tag, "flag after transition");
        chk(ext_req, exp_req, tag, "request after transition");
      end
    end

    // R7: flag sets while disabled, request gated
    ext_pin = 1'b0; tick(3);
    set_sense(2'b11);
    set_ext_en(1'b0);
    w1c(2'b01);
    ext_pin = 1'b1; tick(3);
    chk(ext_flag, 1'b1, "R7", "flag sets with enable off");
    chk(ext_req, 1'b0, "R7", "request gated by enable");
    set_ext_en(1'b1);
    chk(ext_req, 1'b1, "R7", "request follows flag once enabled");

    // R6: sticky, ack clear, clear-bit decoding, event beats clear
    tick(5);
    chk(ext_flag, 1'b1, "R6", "flag held without clear");
    ext_ack = 1'b1; tick(1); ext_ack = 1'b0;
    chk(ext_flag, 1'b0, "R6", "flag cleared by ack");
    ext_pin = 1'b0; tick(3);
    ext_pin = 1'b1; tick(3);
    chk(ext_flag, 1'b1, "R6", "flag set again on rise");
    w1c(2'b10);
    chk(ext_flag, 1'b1, "R6", "group clear bit leaves ext flag");
    w1c(2'b01);
    chk(ext_flag, 1'b0, "R6", "ext clear bit clears flag");
    set_sense(2'b01);
    ext_pin = 1'b0; tick(2);
    ext_ack = 1'b1; tick(1); ext_ack = 1'b0;
    chk(ext_flag, 1'b1, "R6", "event beats simultaneous ack");

    // R8/R9: sweep of all masks against each pin
    set_grp_en(1'b1);
    for (int mk = 0; mk < (1 << NP); mk++) begin
      set_mask(mk[NP-1:0]);
      for (int p = 0; p < NP; p++) begin
        logic exp_g;
        w1c(2'b10);
        exp_g = mk[p];
        grp_pin[p] = ~grp_pin[p];
        tick(3);
        chk(grp_flag, exp_g, exp_g ? "R8" : "R9", "group flag after single-pin toggle");
        chk(grp_req,  exp_g, "R8", "group request after single-pin toggle");
      end
    end

    // R8: latency and multi-pin toggle
    set_mask(6'b000100);
    w1c(2'b10);
    grp_pin[2:0] = ~grp_pin[2:0]; tick(2);
    chk(grp_flag, 1'b0, "R8", "group flag one edge before due");
    tick(1);
    chk(grp_flag, 1'b1, "R8", "group flag with one masked pin among three");
    w1c(2'b10);
    grp_pin[1:0] = ~grp_pin[1:0]; tick(3);
    chk(grp_flag, 1'b0, "R9", "unmasked pins only");

    // R9: group enable off
    set_mask('1);
    set_grp_en(1'b0);
    grp_pin = ~grp_pin; tick(3);
    chk(grp_flag, 1'b0, "R9", "all pins toggled with group enable off");
    chk(grp_req,  1'b0, "R9", "no group request with enable off");

    // R10: clear sources for the group flag
    set_grp_en(1'b1);
    grp_pin[5] = ~grp_pin[5]; tick(3);
    chk(grp_flag, 1'b1, "R10", "group flag set");
    ext_ack = 1'b1; tick(1); ext_ack = 1'b0;
    chk(grp_flag, 1'b1, "R10", "ext ack leaves group flag");
    w1c(2'b01);
    chk(grp_flag, 1'b1, "R10", "ext clear bit leaves group flag");
    grp_ack = 1'b1; tick(1); grp_ack = 1'b0;
    chk(grp_flag, 1'b0, "R10", "group ack clears flag");
    grp_pin[4] = ~grp_pin[4]; tick(3);
    w1c(2'b10);
    chk(grp_flag, 1'b0, "R10", "group clear bit clears flag");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule